// File: doc/BRIEF.md
# Serial port status flag register

This block is the eight-bit status register of a serial communication controller. Hardware elsewhere in the controller raises one-cycle pulses when a transmit or receive event happens. The block turns each pulse into a sticky flag that the CPU can see and clear. It also tracks the transmitter-idle level, records the multiprocessor bit of each received frame, and holds the multiprocessor bit that the transmitter sends with its next frame.

The CPU can clear an event flag only in a fixed order. It must first read the register while the flag is 1, and then write a 0 to that bit in a later cycle. A 0 written without that earlier read does nothing, and writing a 1 never sets a flag. A standby input reloads the reset value in the same way as the synchronous reset.

Top module: `sio_status_reg`

## Requirements
- R1: The bit layout of `rd_data`, from bit 7 down to bit 0, is: transmit-empty, receive-full, overrun, framing/error-signal, parity, transmit-end, received multiprocessor bit, transmit multiprocessor bit.
- R2: While `rst` or `standby` is high at a clock edge, the register loads 0x84 (transmit-empty = 1, transmit-end = 1, every other bit 0), and `mpbt_o` is 0.
- R3: A one-cycle set pulse on any of the five event inputs makes the matching flag read 1 from the next clock edge on.
- R4: A CPU write with a 1 in an event-flag bit leaves that flag unchanged.
- R5: A CPU write with a 0 in an event-flag bit leaves the flag at 1 if the flag was not read as 1 in an earlier cycle since it was last set.
- R6: If a read strobe returns an event flag as 1, then a later write of 0 to that bit clears it at the write's clock edge. The flag stays eligible for clearing until it is cleared.
- R7: If a set pulse and a clearing write reach the same flag in the same cycle, the flag stays 1. A further write of 0 then needs a fresh read before it can clear the flag.
- R8: Bit 2 (transmit-end) equals `tx_idle_i` as sampled at the previous clock edge. CPU writes do not change it.
- R9: Bit 1 captures `rx_mpb_i` at each receive-full set pulse. CPU writes do not change it.
- R10: Bit 0 takes `wr_data[0]` on every write strobe, and `mpbt_o` always equals bit 0.
- R11: A read that returns an event flag as 0 does not make that flag eligible for clearing after a later set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Standby entry; reloads the reset value |
| set_tx_empty_i | input | 1 | Pulse: transmit data moved into the shift register |
| set_rx_full_i | input | 1 | Pulse: received byte stored |
| set_overrun_i | input | 1 | Pulse: receive overrun detected |
| set_framing_i | input | 1 | Pulse: framing error or error signal detected |
| set_parity_i | input | 1 | Pulse: parity error detected |
| tx_idle_i | input | 1 | Transmitter idle level |
| rx_mpb_i | input | 1 | Multiprocessor bit of the frame being stored |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| rd_data | output | 8 | Current register value |
| mpbt_o | output | 1 | Multiprocessor bit for the next transmitted frame |

## Verification
The assertions check on every cycle the rules that concern a single flag. A flag never rises without a set pulse. A set pulse always leaves the flag at 1. A flag that is not eligible for clearing holds its value. An eligible write of 0 clears the flag. They also check that transmit-end follows the idle input and that the received multiprocessor bit is captured on each receive-full pulse. Only the bench scenarios show the ordering rules that span several CPU accesses: that eligibility persists across partial writes, that it is lost after a set/clear collision, and that a read which returns 0 does not make a flag eligible.

// File: rtl/sio_status_pkg.sv
package sio_status_pkg;
    localparam int STAT_W  = 8;
    localparam int EVT_N   = 5;
    localparam int EVT_LSB = STAT_W - EVT_N;

    // Event flag indices within the evt field (index i sits at bit i+EVT_LSB)
    localparam int EV_PAR  = 0;
    localparam int EV_FRM  = 1;
    localparam int EV_OVR  = 2;
    localparam int EV_RXF  = 3;
    localparam int EV_TXE  = 4;

    typedef struct packed {
        logic [EVT_N-1:0] evt;
        logic             tend;
        logic             mpb;
        logic             mpbt;
    } stat_t;

    localparam logic [STAT_W-1:0] STAT_RST = 8'h84;

    function automatic logic evt_rst_bit(input int idx);
        return STAT_RST[idx + EVT_LSB];
    endfunction
endpackage

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic set_i,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag_o
);
    logic flag_q, armed_q;
    logic clr_req;

    assign clr_req = wr_en && !wr_bit && armed_q;

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            flag_q  <= RST_VAL;
            armed_q <= 1'b0;
        end else begin
            if (set_i)        flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;

            if (clr_req)                armed_q <= 1'b0;
            else if (rd_en && flag_q)   armed_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    // R3: flag only rises through a set pulse
    a_r3_no_rise_without_set: assert property (@(posedge clk) disable iff (rst || standby)
        (!flag_q && !set_i) |=> !flag_q);
    // R7: set pulse always leaves the flag at 1
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst || standby)
        set_i |=> flag_q);
    // R5: unarmed flag holds
    a_r5_hold_unarmed: assert property (@(posedge clk) disable iff (rst || standby)
        (flag_q && !armed_q && !set_i) |=> flag_q);
    // R6: eligible write of zero clears
    a_r6_clear: assert property (@(posedge clk) disable iff (rst || standby)
        (wr_en && !wr_bit && armed_q && !set_i) |=> !flag_q);
endmodule

// File: rtl/sio_aux_bits.sv
module sio_aux_bits (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic tx_idle_i,
    input  logic rx_store_i,
    input  logic rx_mpb_i,
    input  logic wr_en,
    input  logic wr_mpbt,
    output logic tend_o,
    output logic mpb_o,
    output logic mpbt_o
);
    import sio_status_pkg::*;
    localparam stat_t RST_S = stat_t'(STAT_RST);

    logic tend_q, mpb_q, mpbt_q;

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            tend_q <= RST_S.tend;
            mpb_q  <= RST_S.mpb;
            mpbt_q <= RST_S.mpbt;
        end else begin
            tend_q <= tx_idle_i;
            if (rx_store_i) mpb_q  <= rx_mpb_i;
            if (wr_en)      mpbt_q <= wr_mpbt;
        end
    end

    assign tend_o = tend_q;
    assign mpb_o  = mpb_q;
    assign mpbt_o = mpbt_q;

    // R8: transmit-end tracks the idle level one edge later
    a_r8_tend_follows: assert property (@(posedge clk) disable iff (rst || standby)
        1'b1 |=> (tend_o == $past(tx_idle_i)));
    // R9: received multiprocessor bit captured on store
    a_r9_mpb_capture: assert property (@(posedge clk) disable iff (rst || standby)
        rx_store_i |=> (mpb_o == $past(rx_mpb_i)));
    // R9: without a store the received bit is stable
    a_r9_mpb_hold: assert property (@(posedge clk) disable iff (rst || standby)
        !rx_store_i |=> $stable(mpb_o));
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
    import sio_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              set_tx_empty_i,
    input  logic              set_rx_full_i,
    input  logic              set_overrun_i,
    input  logic              set_framing_i,
    input  logic              set_parity_i,
    input  logic              tx_idle_i,
    input  logic              rx_mpb_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    output logic              mpbt_o
);
    stat_t            stat;
    logic [EVT_N-1:0] set_vec;

    always_comb begin
        set_vec         = '0;
        set_vec[EV_TXE] = set_tx_empty_i;
        set_vec[EV_RXF] = set_rx_full_i;
        set_vec[EV_OVR] = set_overrun_i;
        set_vec[EV_FRM] = set_framing_i;
        set_vec[EV_PAR] = set_parity_i;
    end

    for (genvar i = 0; i < EVT_N; i++) begin : g_evt
        sio_flag_cell #(.RST_VAL(evt_rst_bit(i))) u_cell (
            .clk    (clk),
            .rst    (rst),
            .standby(standby),
            .set_i  (set_vec[i]),
            .rd_en  (rd_en),
            .wr_en  (wr_en),
            .wr_bit (wr_data[i + EVT_LSB]),
            .flag_o (stat.evt[i])
        );
    end

    sio_aux_bits u_aux (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .tx_idle_i (tx_idle_i),
        .rx_store_i(set_rx_full_i),
        .rx_mpb_i  (rx_mpb_i),
        .wr_en     (wr_en),
        .wr_mpbt   (wr_data[0]),
        .tend_o    (stat.tend),
        .mpb_o     (stat.mpb),
        .mpbt_o    (stat.mpbt)
    );

    assign rd_data = stat;
    assign mpbt_o  = stat.mpbt;

    // R2: reset or standby reloads the reset value
    a_r2_reset_value: assert property (@(posedge clk)
        (rst || standby) |=> (rd_data == STAT_RST));
    // R10: transmit multiprocessor bit follows each write
    a_r10_mpbt_write: assert property (@(posedge clk) disable iff (rst || standby)
        wr_en |=> (mpbt_o == $past(wr_data[0])));
endmodule

// File: tb/sio_status_reg_tb_top.sv
module sio_status_reg_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] OP_SET = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_WR  = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] arg;
        logic [7:0] exp;
    } vec_t;

    // Starts from reset value 0x84, tx_idle=1, rx_mpb=0
    localparam vec_t VEC [10] = '{
        '{OP_WR,  8'h00, 8'h84},  // R5 write 0 without read
        '{OP_RD,  8'h00, 8'h84},  // R1 read arms transmit-empty
        '{OP_WR,  8'h00, 8'h04},  // R6 clear
        '{OP_WR,  8'hFF, 8'h05},  // R4 ones do not set, R10 mpbt
        '{OP_SET, 8'h78, 8'h7D},  // R3 four receive flags
        '{OP_WR,  8'h01, 8'h7D},  // R5 unarmed zeros ignored
        '{OP_RD,  8'h00, 8'h7D},  // R6 arm
        '{OP_WR,  8'h41, 8'h45},  // R6 partial clear
        '{OP_WR,  8'h01, 8'h05},  // R6 arm persists
        '{OP_SET, 8'h80, 8'h85}   // R3 transmit-empty
    };

    logic clk = 1'b0;
    logic rst, standby;
    logic s_txe, s_rxf, s_ovr, s_frm, s_par;
    logic tx_idle, rx_mpb, rd_en, wr_en;
    logic [7:0] wr_data, rd_data;
    logic mpbt;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_status_reg dut_i (
        .clk(clk), .rst(rst), .standby(standby),
        .set_tx_empty_i(s_txe), .set_rx_full_i(s_rxf), .set_overrun_i(s_ovr),
        .set_framing_i(s_frm), .set_parity_i(s_par),
        .tx_idle_i(tx_idle), .rx_mpb_i(rx_mpb),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .mpbt_o(mpbt)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        {s_txe, s_rxf, s_ovr, s_frm, s_par} = '0;
        rd_en = 0; wr_en = 0; wr_data = '0; standby = 0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        s_txe = m[7]; s_rxf = m[6]; s_ovr = m[5]; s_frm = m[4]; s_par = m[3];
    endtask

    // Drive at negedge, let one posedge pass, sample 1 time unit later
    task automatic step();
        @(posedge clk); #1;
        idle_in();
        @(negedge clk);
    endtask

    task automatic do_read(input string req, input logic [7:0] exp);
        rd_en = 1; #1;
        check8(req, rd_data, exp);
        step();
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1; wr_data = d;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        idle_in();
        tx_idle = 1; rx_mpb = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0; #1;
        check8("R2 reset value", rd_data, 8'h84);
        check8("R10 mpbt after reset", {7'd0, mpbt}, 8'h00);

        for (int i = 0; i < 10; i++) begin
            case (VEC[i].op)
                OP_SET:  begin set_mask(VEC[i].arg); step(); check8("R3 vector", rd_data, VEC[i].exp); end
                OP_RD:   do_read("R1 vector read", VEC[i].exp);
                default: begin do_write(VEC[i].arg); check8("R4 R5 R6 vector", rd_data, VEC[i].exp); end
            endcase
        end

        // R7: collision of set and clear
        do_read("R7 arm read", 8'h85);
        s_txe = 1; do_write(8'h01);
        check8("R7 set wins", rd_data, 8'h85);
        do_write(8'h01);
        check8("R7 arm dropped", rd_data, 8'h85);

        // R11: read while 0 does not arm
        do_read("R11 read zero", 8'h85);
        set_mask(8'h40); step();
        check8("R11 set rx full", rd_data, 8'hC5);
        do_write(8'h81);
        check8("R11 not armed", rd_data, 8'hC5);

        // R8: transmit-end follows idle level
        tx_idle = 0; step();
        check8("R8 tend low", rd_data, 8'hC1);
        do_write(8'hFF);
        check8("R8 write ignored", rd_data, 8'hC1);
        tx_idle = 1; step();
        check8("R8 tend high", rd_data, 8'hC5);

        // R9: received mpb capture, R10 mpbt
        rx_mpb = 1; set_mask(8'h40); step(); rx_mpb = 0;
        check8("R9 mpb captured", rd_data, 8'hC7);
        do_write(8'hC5);
        check8("R9 mpb write ignored", rd_data, 8'hC7);
        check8("R10 mpbt_o high", {7'd0, mpbt}, 8'h01);
        do_write(8'hC4);
        check8("R10 mpbt cleared", rd_data, 8'hC6);
        check8("R10 mpbt_o low", {7'd0, mpbt}, 8'h00);

        // R2: standby reload
        standby = 1; step();
        check8("R2 standby value", rd_data, 8'h84);
        check8("R2 mpbt after standby", {7'd0, mpbt}, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule